// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory. When the load strobe is high at a rising clock edge, the block captures the full start address and the ordering mode. On later edges where the advance input is high, it steps to the next beat. The upper address bits never change during a burst. Only the low two bits follow the selected beat order.

Two beat orders are supported. In interleaved order, the low bits are the start bits XORed with the beat count. In linear order, the low bits are the start bits plus the beat count, wrapping modulo four. After the fourth beat the sequence returns to the start address.

No data passes through this block, so it has no valid/ready handshake. Load, advance and mode are plain level controls that are sampled on every rising edge. The output is always valid and cannot be stalled: holding advance low is the only way to suspend the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after its release until the first load, word_addr_o is all zeros.
- R2: A load (load_i=1 at a rising edge) makes word_addr_o equal the start_addr_i value sampled at that edge, starting with the next cycle.
- R3: A load takes priority over advance. With both high at one edge, the output is the new start address. This also applies mid-burst, where the sequence restarts from the new address.
- R4: Each edge with adv_i=1 and load_i=0 moves the output to the next beat of the burst.
- R5: An edge with adv_i=0 and load_i=0 leaves word_addr_o unchanged.
- R6: Mode 0 (lin_mode_i=0 at load) is interleaved: the low two bits of word_addr_o equal the loaded low two bits XOR the beat count (0..3).
- R7: Mode 1 (lin_mode_i=1 at load) is linear: the low two bits equal the loaded low two bits plus the beat count, modulo 4.
- R8: Bits [ADDR_W-1:2] of word_addr_o stay equal to the loaded upper bits for the whole burst, and a wrap of the low bits never carries into them.
- R9: The advance that follows the fourth beat returns the output to the loaded start address.
- R10: lin_mode_i is sampled only at a load. Changing it mid-burst does not alter the ordering.
- R11: Changes on start_addr_i without a load do not affect word_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Address strobe: capture start address and mode |
| adv_i | input | 1 | Step to the next beat |
| lin_mode_i | input | 1 | Ordering select, sampled at load: 0 interleaved, 1 linear |
| start_addr_i | input | ADDR_W | Full start word address |
| word_addr_o | output | ADDR_W | Current word address |

## Verification
The assertions check these rules on every cycle:
- a load clears the beat count and presents the captured address;
- the count holds without advance and steps by one with it;
- the upper bits and the captured mode stay stable between loads.

Some behaviour can only be shown by the bench's scenarios:
- the exact interleaved and linear beat orders, for several start offsets;
- the wrap back to the start on the fifth beat;
- the carry-free wrap when the start address sits near an upper-bit boundary;
- that mode and address changes without a load are ignored.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (adv_i)  beat_o <= beat_o + 1'b1;
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> beat_o == '0); // R3
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(beat_o)); // R5
  AST_STEP_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1)); // R4
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] ilv_w;
  logic [BEAT_W-1:0] lin_w;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  assign lin_w = start_i + beat_i;

  always_comb begin
    unique case (order_i)
      ORD_LINEAR: low_o = lin_w;
      default:    low_o = ilv_w;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              lin_mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] word_addr_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] beat_w;
  logic [BEAT_W-1:0] low_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load_i) begin
      base_q  <= start_addr_i;
      order_q <= order_e'(lin_mode_i);
    end
  end

  bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .adv_i  (adv_i),
    .beat_o (beat_w)
  );

  bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order_q),
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat_w),
    .low_o   (low_w)
  );

  assign word_addr_o = {base_q[ADDR_W-1:BEAT_W], low_w};

  AST_LOAD_PRESENTS_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> word_addr_o == $past(start_addr_i)); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> word_addr_o[ADDR_W-1 -: HI_W] == $past(word_addr_o[ADDR_W-1 -: HI_W])); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(order_q)); // R10
  AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(word_addr_o)); // R5
endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          lin_mode_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [AW-1:0] word_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_lin = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .lin_mode_i(lin_mode_i), .start_addr_i(start_addr_i),
    .word_addr_o(word_addr_o)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = m_lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit ld, input bit adv, input bit md,
                    input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    load_i = ld; adv_i = adv; lin_mode_i = md; start_addr_i = a;
    if (ld) begin
      m_base = a; m_cnt = 2'd0; m_lin = md;
    end else if (adv) begin
      m_cnt = m_cnt + 2'd1;
    end
    exp_q.push_back(model_addr());
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(word_addr_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(word_addr_o, '0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(word_addr_o, '0, "R1 after reset");

    // interleaved, start low bits 01
    op(1, 0, 0, 18'h2A5F1, "R2 load interleaved");
    op(0, 1, 0, 18'h2A5F1, "R6 beat1");
    op(0, 1, 0, 18'h2A5F1, "R6 beat2");
    op(0, 1, 0, 18'h2A5F1, "R6 beat3");
    op(0, 1, 0, 18'h2A5F1, "R9 wrap interleaved");
    // linear, start low bits 10, upper near a boundary
    op(1, 0, 1, 18'h1FFFE, "R2 load linear");
    op(0, 1, 1, 18'h1FFFE, "R7 beat1");
    op(0, 1, 1, 18'h1FFFE, "R8 no carry beat2");
    op(0, 1, 1, 18'h1FFFE, "R7 beat3");
    op(0, 1, 1, 18'h1FFFE, "R9 wrap linear");
    // hold while start and mode move
    op(0, 0, 0, 18'h00000, "R5 hold");
    op(0, 0, 1, 18'h3FFFF, "R11 start ignored");
    op(0, 0, 0, 18'h12345, "R10 mode ignored during hold");
    // mode change mid-burst: ordering stays linear
    op(0, 1, 0, 18'h12345, "R10 mode change mid-burst");
    op(0, 1, 0, 18'h12345, "R4 step");
    // load and advance together
    op(1, 1, 0, 18'h0ABC3, "R3 load beats advance");
    op(0, 1, 0, 18'h0ABC3, "R6 start 11 beat1");
    op(0, 1, 0, 18'h0ABC3, "R6 start 11 beat2");
    // restart mid-burst
    op(1, 0, 1, 18'h30003, "R3 restart mid-burst");
    op(0, 1, 1, 18'h30003, "R7 start 11 beat1");
    op(0, 0, 1, 18'h30003, "R5 suspend");
    op(0, 1, 1, 18'h30003, "R7 start 11 beat2");
    op(0, 1, 1, 18'h30003, "R8 upper fixed beat3");
    op(0, 0, 0, 18'h00000, "R5 final hold");

    @(negedge clk); load_i = 0; adv_i = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule